// File: doc/BRIEF.md
# Majority-Vote Register Read Filter

This block stands between a requester and a register source whose reads sometimes return corrupted data. One read request makes the block fetch the same source register again and again. It keeps a table of every distinct 32-bit value seen during that request, along with how many times each value has appeared. It then answers with the value that appeared most often.

Sampling stops early once any single value has been seen in more than half of the maximum number of fetches. If no value gets there, sampling runs to the full number of fetches and the block returns the current leader. The block handles one request at a time.

The controller has three states:
- `ST_IDLE`: waits for a request with `req_ready` high.
- `ST_FETCH`: holds `smp_req` high and counts each accepted sample.
- `ST_REPLY`: pulses `rsp_valid` for one cycle.

It has four transitions:
- `ST_IDLE` to `ST_FETCH` on an accepted request.
- `ST_FETCH` to `ST_FETCH` while sampling continues.
- `ST_FETCH` to `ST_REPLY` on a majority, or when the last sample is taken.
- `ST_REPLY` to `ST_IDLE`, always.

Top module: `mode_read_filter`

## Requirements
- R1: After reset, `req_ready` is 1, `smp_req` is 0 and `rsp_valid` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. In the next cycle `smp_req` is 1, `smp_addr` equals the accepted `req_addr`, and `req_ready` stays 0 until the response has been given.
- R3: A sample is taken only on an edge where `smp_req` and `smp_ack` are both 1. While `smp_ack` is 0, `smp_req` stays at 1 and `smp_addr` does not change.
- R4: The tally of values is emptied when a request is accepted. Each sample either adds one to the count of an equal value already in the tally, or is added as a new value with a count of 1. The tally holds up to SAMPLES (default 100) distinct values.
- R5: The leader changes only when a value's count becomes strictly greater than the leader's count. The leader's count never falls during a request.
- R6: When a sample raises some value's count above SAMPLES/2 (default: to 51), no further sample is requested, and that value is returned.
- R7: If no value reaches a majority, exactly SAMPLES samples are taken and the leader is returned.
- R8: If two values end with equal top counts, the value that reached that count first is returned.
- R9: `rsp_valid` is high for exactly one cycle: the cycle after the edge that took the final sample. `rsp_data` carries the result in that cycle, and `req_ready` is 1 in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request |
| req_addr | input | ADDR_W | Register address to filter |
| req_ready | output | 1 | Idle; a request may be accepted |
| smp_req | output | 1 | Sample request toward the source |
| smp_addr | output | ADDR_W | Address of the register being sampled |
| smp_ack | input | 1 | Source presents `smp_data` this cycle |
| smp_data | input | DATA_W | Sampled register value |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Filtered (most frequent) value |

## Verification
- **Start of sampling:** `smp_req` is due one cycle after the edge that accepts a request.
- **Per-sample timing:** each sample counts on the edge where `smp_ack` is high.
- **Response:** `rsp_valid` rises in the cycle straight after the edge that takes the final sample, and falls one cycle later.

The bench drives the source and reads every output on the falling edge. The number of samples is therefore the count of falling edges on which the bench presents data with `smp_ack` high while `smp_req` is high. The response is checked on the first falling edge where `rsp_valid` is seen, and the return to idle on the falling edge after that.

// File: rtl/mvf_pkg.sv
package mvf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_REPLY = 2'd2
    } mvf_state_e;
endpackage

// File: rtl/mvf_tally.sv
module mvf_tally #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 100,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              upd,
    input  logic [DATA_W-1:0] sample,
    output logic [CNT_W-1:0]  new_count
);
    localparam int IDX_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] vals [DEPTH];
    logic [CNT_W-1:0]  cnts [DEPTH];
    logic [IDX_W-1:0]  used;
    logic [DEPTH-1:0]  hit_vec;
    logic [DEPTH-1:0]  wr_vec;
    logic              hit;
    logic [CNT_W-1:0]  hit_cnt;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign hit_vec[g] = (IDX_W'(g) < used) && (vals[g] == sample);
        assign wr_vec[g]  = upd && (hit ? hit_vec[g] : (used == IDX_W'(g)));
        always_ff @(posedge clk) begin
            if (wr_vec[g]) begin
                vals[g] <= sample;
                cnts[g] <= new_count;
            end
        end
    end

    always_comb begin
        hit     = |hit_vec;
        hit_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) hit_cnt = cnts[i];
        end
        new_count = hit ? hit_cnt + CNT_W'(1) : CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            used <= '0;
        else if (upd && !hit && used < IDX_W'(DEPTH))
            used <= used + IDX_W'(1);
    end

    // R4
    tally_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R4
    tally_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clear && !hit && used < IDX_W'(DEPTH)) |=> used == $past(used) + IDX_W'(1));
    // R4
    tally_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> used == '0);
endmodule

// File: rtl/mvf_leader.sv
module mvf_leader #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              upd,
    input  logic [DATA_W-1:0] sample,
    input  logic [CNT_W-1:0]  new_count,
    output logic [DATA_W-1:0] lead_val,
    output logic [CNT_W-1:0]  lead_cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            lead_val <= '0;
            lead_cnt <= '0;
        end else if (upd && new_count > lead_cnt) begin
            lead_val <= sample;
            lead_cnt <= new_count;
        end
    end

    // R5
    leader_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> lead_cnt >= $past(lead_cnt));
    // R8
    leader_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && upd && new_count <= lead_cnt) |=> $stable(lead_val));
endmodule

// File: rtl/mvf_ctrl.sv
module mvf_ctrl
    import mvf_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SAMPLES = 100,
    parameter int CNT_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              smp_req,
    output logic [ADDR_W-1:0] smp_addr,
    input  logic              smp_ack,
    input  logic [CNT_W-1:0]  new_count,
    output logic              clear,
    output logic              upd,
    output logic              rsp_valid
);
    localparam int MAJ = SAMPLES / 2;

    mvf_state_e        state, state_nx;
    logic [CNT_W-1:0]  taken;
    logic [ADDR_W-1:0] addr_q;
    logic              finish;

    assign finish = (new_count > CNT_W'(MAJ)) || (taken == CNT_W'(SAMPLES - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_FETCH;
            ST_FETCH: if (smp_ack && finish) state_nx = ST_REPLY;
            ST_REPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            taken  <= '0;
            addr_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                taken  <= '0;
                addr_q <= req_addr;
            end else if (upd) begin
                taken <= taken + CNT_W'(1);
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        smp_req   = 1'b0;
        clear     = 1'b0;
        upd       = 1'b0;
        rsp_valid = 1'b0;
        unique case (state)
            ST_IDLE:  begin req_ready = 1'b1; clear = req_valid; end
            ST_FETCH: begin smp_req = 1'b1; upd = smp_ack; end
            ST_REPLY: rsp_valid = 1'b1;
            default:  ;
        endcase
    end
    assign smp_addr = addr_q;

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> smp_req && smp_addr == $past(req_addr));
    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req && !smp_ack) |=> smp_req && $stable(smp_addr));
    // R6
    early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && new_count > CNT_W'(MAJ)) |=> rsp_valid);
    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);
endmodule

// File: rtl/mode_read_filter.sv
module mode_read_filter #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int SAMPLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              smp_req,
    output logic [ADDR_W-1:0] smp_addr,
    input  logic              smp_ack,
    input  logic [DATA_W-1:0] smp_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int CNT_W = $clog2(SAMPLES + 1);

    logic              clear, upd;
    logic [CNT_W-1:0]  new_count, lead_cnt;
    logic [DATA_W-1:0] lead_val;

    mvf_ctrl #(.ADDR_W(ADDR_W), .SAMPLES(SAMPLES), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .smp_req(smp_req), .smp_addr(smp_addr),
        .smp_ack(smp_ack), .new_count(new_count), .clear(clear), .upd(upd),
        .rsp_valid(rsp_valid)
    );

    mvf_tally #(.DATA_W(DATA_W), .DEPTH(SAMPLES), .CNT_W(CNT_W)) u_tally (
        .clk(clk), .rst_n(rst_n), .clear(clear), .upd(upd),
        .sample(smp_data), .new_count(new_count)
    );

    mvf_leader #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_leader (
        .clk(clk), .rst_n(rst_n), .clear(clear), .upd(upd), .sample(smp_data),
        .new_count(new_count), .lead_val(lead_val), .lead_cnt(lead_cnt)
    );

    assign rsp_data = rsp_valid ? lead_val : '0;

    // R7
    cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lead_cnt <= CNT_W'(SAMPLES));
endmodule

// File: tb/sim_mode_read_filter.sv
module sim_mode_read_filter;
    typedef struct packed {
        logic [1:0]  mode;
        logic [7:0]  param;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp_val;
        logic [7:0]  exp_n;
    } vec_t;

    localparam logic [31:0] VA = 32'hCAFE_0001;
    localparam logic [31:0] VB = 32'h1000_0000;
    localparam int NV = 7;
    // mode 0: b when k%param==0 else a; mode 1: b+k when k%param==0 else a;
    // mode 2: b when k<param else a
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd1,  VA, VB, VB, 8'd51},   // R6 clean stream
        '{2'd0, 8'd3,  VA, VB, VA, 8'd77},   // R6 glitch every third
        '{2'd1, 8'd2,  VA, VB, VA, 8'd100},  // R7 distinct glitches, no majority
        '{2'd0, 8'd2,  VA, VB, VB, 8'd100},  // R8 50/50 tie
        '{2'd2, 8'd30, VA, VB, VA, 8'd81},   // R5 leader changes
        '{2'd2, 8'd60, VA, VB, VB, 8'd51},   // R6 burst wins
        '{2'd1, 8'd1,  VA, VB, VB, 8'd100}   // R4 full table, all distinct
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic [7:0]  req_addr = 0;
    logic        req_ready, smp_req, rsp_valid;
    logic [7:0]  smp_addr;
    logic        smp_ack = 0;
    logic [31:0] smp_data = 0;
    logic [31:0] rsp_data;
    int tests = 0, fails = 0, cycles = 0;

    always #2.5 clk = ~clk;

    mode_read_filter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .smp_req(smp_req), .smp_addr(smp_addr),
        .smp_ack(smp_ack), .smp_data(smp_data), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: act=%0d exp<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input vec_t v, input int k);
        unique case (v.mode)
            2'd0: return (k % v.param == 0) ? v.b : v.a;
            2'd1: return (k % v.param == 0) ? v.b + 32'(k) : v.a;
            default: return (k < v.param) ? v.b : v.a;
        endcase
    endfunction

    task automatic run_req(input vec_t v, input logic [7:0] addr, input bit stall);
        int k = 0;
        int it = 0;
        bit got = 0;
        bit addr_ok = 1;
        bit ackp;
        @(negedge clk);
        req_valid = 1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0 && smp_req == 1, "R2 busy after accept",
            {30'd0, req_ready, smp_req}, 32'd1);
        while (!got && it < 1000) begin
            if (rsp_valid) begin
                got = 1;
            end else begin
                if (smp_req) begin
                    if (smp_addr != addr) addr_ok = 0;
                    ackp = stall ? it[0] : 1'b1;
                    smp_ack  = ackp;
                    smp_data = pat(v, k);
                    if (ackp) k++;
                end else begin
                    smp_ack = 0;
                end
                @(negedge clk);
                it++;
            end
        end
        smp_ack = 0;
        chk(addr_ok, "R2 smp_addr", {24'd0, smp_addr}, {24'd0, addr});
        chk(got && rsp_data == v.exp_val, "R6/R7/R8 result", rsp_data, v.exp_val);
        chk(k == int'(v.exp_n), stall ? "R3 samples under stall" : "R6/R7 sample count",
            32'(k), {24'd0, v.exp_n});
        @(negedge clk);
        chk(rsp_valid == 0 && req_ready == 1, "R9 one-cycle pulse",
            {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(req_ready == 1, "R1 ready", {31'd0, req_ready}, 32'd1);
        chk(smp_req == 0, "R1 smp_req", {31'd0, smp_req}, 32'd0);
        chk(rsp_valid == 0, "R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && smp_req == 0, "R1 idle after reset",
            {30'd0, req_ready, smp_req}, 32'd2);
        // table walk; back-to-back requests also exercise R4 tally clearing
        for (int i = 0; i < NV; i++) run_req(VECS[i], 8'h40 + 8'(i), 1'b0);
        // R3 source stalls every other cycle
        run_req(VECS[1], 8'hA5, 1'b1);
        // R4 R5 repeat after a different stream: old counts must not carry over
        run_req(VECS[3], 8'h11, 1'b0);
        run_req(VECS[0], 8'h12, 1'b0);
        // R1 reset mid-request
        @(negedge clk);
        req_valid = 1;
        req_addr  = 8'h77;
        @(negedge clk);
        req_valid = 0;
        rst_n = 0;
        @(negedge clk);
        chk(req_ready == 1 && smp_req == 0, "R1 reset while busy",
            {30'd0, req_ready, smp_req}, 32'd2);
        rst_n = 1;
        run_req(VECS[4], 8'h33, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule